// File: doc/BRIEF.md
# Dual-Thread Control List Sequencer

This block is the front end of a tiled renderer. It runs two command-list threads. Thread 0 bins primitives. Thread 1 renders the tiles. Each thread owns a current-address register and an end-address register. A thread fetches 32-bit command words, one per acknowledged request, for as long as its two addresses differ. It goes idle as soon as they match. The host writes the registers through a small write port and reads the two event counters directly as outputs.

Most words are forwarded downstream untouched. A few synchronisation opcodes are acted on here instead. Two opposite-direction semaphores throttle the threads against each other. The binning thread's increment is held back until its next flush, so the render side cannot run ahead of tile lists that have not yet been written. A binning flush raises a one-cycle interrupt so the host can kick the render thread.

Top module: `cl_seq`

## Requirements
- R1: After reset both threads are idle with no fetch request, both counters and both semaphores read zero, and `flush_irq` is low.
- R2: Loading a thread's current address (host_sel 0) copies the value into its end register as well, which halts the thread. Loading the end address (host_sel 1) starts the thread. It requests words at its current address until the current address equals the end address.
- R3: Each acknowledged word that is not stalled advances the address by 4. Without an acknowledge the address holds.
- R4: The opcode is bits [31:24] of the word: 0x11 flush, 0x12 final tile store, 0x13 semaphore increment, 0x14 semaphore wait. A word a thread does not act on raises its `cmd_valid` bit in the cycle it is acknowledged, with the word on `cmd_word`. Words the thread acts on never appear downstream.
- R5: A wait on a semaphore holding zero stalls the thread: the address is held and nothing is consumed. A nonzero count is decremented one cycle later and the thread proceeds. Thread 0 waits on `sem_to_bin`; thread 1 waits on `sem_to_rnd`.
- R6: An increment executed by the render thread raises `sem_to_bin` by one in the next cycle.
- R7: An increment executed by the binning thread is only remembered. It raises `sem_to_rnd` when the binning thread next executes a flush. An increment that follows the last flush of a list never takes effect, and loading the binning current address discards it.
- R8: A flush executed by the binning thread raises `bin_flush_cnt` by one and pulses `flush_irq` high for exactly the following cycle.
- R9: A final tile store executed by the render thread raises `rnd_done_cnt` by one.
- R10: A flush fetched by the render thread, and a final tile store fetched by the binning thread, are forwarded downstream as ordinary words and change no counter and no interrupt.
- R11: Each semaphore saturates at 15; further increments leave it at 15.
- R12: A host write with host_sel 2 clears `bin_flush_cnt`, and one with host_sel 3 clears `rnd_done_cnt`. A clear wins over a same-cycle increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_thr | input | 1 | Target thread for address writes (0 binning, 1 render) |
| host_sel | input | 2 | 0 current address, 1 end address, 2 clear flush count, 3 clear render count |
| host_wdata | input | ADDR_W | Address value written |
| fetch_req | output | 2 | Per-thread word fetch request |
| fetch_addr | output | 2*ADDR_W | Per-thread fetch address |
| fetch_ack | input | 2 | Per-thread acknowledge; data valid in the same cycle |
| fetch_data | input | 2*32 | Per-thread fetched word |
| cmd_valid | output | 2 | Per-thread forwarded-word strobe |
| cmd_word | output | 2*32 | Per-thread forwarded word |
| thread_busy | output | 2 | Thread running (current differs from end) |
| sem_to_bin | output | 4 | Semaphore the binning thread waits on |
| sem_to_rnd | output | 4 | Semaphore the render thread waits on |
| bin_flush_cnt | output | CNT_W | Binning flush count |
| rnd_done_cnt | output | CNT_W | Final tile store count |
| flush_irq | output | 1 | One-cycle pulse after a binning flush |

## Verification
The bench stalls the render thread on an empty semaphore. It checks that the address is frozen and nothing is forwarded, so a design that let the wait slip through would emit the following word early. It places an increment after the last binning flush and confirms the render semaphore never moves; a design applying increments immediately would over-release the render thread. It drives seventeen increments into one semaphore to catch a count that wraps to zero instead of sticking at 15. It withholds the acknowledge to catch an address that advances on a bare request. Flush and store words sent to the wrong thread are checked to be forwarded rather than counted, which exposes decoding that ignores the thread.

// File: rtl/cl_seq_pkg.sv
package cl_seq_pkg;
    localparam logic [7:0] OP_FLUSH     = 8'h11;
    localparam logic [7:0] OP_STORE_END = 8'h12;
    localparam logic [7:0] OP_SEM_INC   = 8'h13;
    localparam logic [7:0] OP_SEM_WAIT  = 8'h14;

    localparam int NTHR       = 2;
    localparam int TH_BIN     = 0;
    localparam int TH_RND     = 1;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        HS_CUR     = 2'd0,
        HS_END     = 2'd1,
        HS_CLR_BIN = 2'd2,
        HS_CLR_RND = 2'd3
    } host_sel_e;
endpackage

// File: rtl/cl_seq_addr.sv
module cl_seq_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_cur,
    input  logic              ld_end,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_o,
    output logic              busy_o
);
    localparam logic [ADDR_W-1:0] INCR = ADDR_W'(cl_seq_pkg::WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] fin;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_cur) begin
            st_d.cur = wdata;
            st_d.fin = wdata;
        end else begin
            if (step)   st_d.cur = st_q.cur + INCR;
            if (ld_end) st_d.fin = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign busy_o = (st_q.cur != st_q.fin);
endmodule

// File: rtl/cl_seq_sem.sv
module cl_seq_sem #(
    parameter int SEM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [SEM_W-1:0] cnt_o
);
    localparam logic [SEM_W-1:0] TOP = {SEM_W{1'b1}};

    logic [SEM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cl_seq.sv
module cl_seq
    import cl_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int SEM_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic                   host_thr,
    input  logic [1:0]             host_sel,
    input  logic [ADDR_W-1:0]      host_wdata,
    output logic [1:0]             fetch_req,
    output logic [1:0][ADDR_W-1:0] fetch_addr,
    input  logic [1:0]             fetch_ack,
    input  logic [1:0][31:0]       fetch_data,
    output logic [1:0]             cmd_valid,
    output logic [1:0][31:0]       cmd_word,
    output logic [1:0]             thread_busy,
    output logic [SEM_W-1:0]       sem_to_bin,
    output logic [SEM_W-1:0]       sem_to_rnd,
    output logic [CNT_W-1:0]       bin_flush_cnt,
    output logic [CNT_W-1:0]       rnd_done_cnt,
    output logic                   flush_irq
);
    typedef struct packed {
        logic             pend_inc;
        logic [CNT_W-1:0] bin_cnt;
        logic [CNT_W-1:0] rnd_cnt;
        logic             irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NTHR-1:0][7:0]       op;
    logic [NTHR-1:0]            live, is_wait, is_inc, sync, step, ld_cur, ld_end;
    logic [NTHR-1:0]            sem_inc, sem_dec;
    logic [NTHR-1:0][SEM_W-1:0] sem_cnt;
    logic                       bin_flush, rnd_store;

    // Thread t waits on semaphore t: 0 is filled by render, 1 by binning flushes.
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign op[t]      = fetch_data[t][31:24];
        assign live[t]    = fetch_req[t] && fetch_ack[t];
        assign is_wait[t] = (op[t] == OP_SEM_WAIT);
        assign is_inc[t]  = (op[t] == OP_SEM_INC);
        assign step[t]    = live[t] && !(is_wait[t] && sem_cnt[t] == '0);
        assign sem_dec[t] = step[t] && is_wait[t];
        assign ld_cur[t]  = host_we && (host_thr == t[0]) && (host_sel == HS_CUR);
        assign ld_end[t]  = host_we && (host_thr == t[0]) && (host_sel == HS_END);
        assign cmd_valid[t] = step[t] && !sync[t];
        assign cmd_word[t]  = fetch_data[t];
        assign fetch_req[t] = thread_busy[t];

        cl_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_cur (ld_cur[t]),
            .ld_end (ld_end[t]),
            .wdata  (host_wdata),
            .step   (step[t]),
            .cur_o  (fetch_addr[t]),
            .busy_o (thread_busy[t])
        );

        cl_seq_sem #(.SEM_W(SEM_W)) u_sem (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (sem_inc[t]),
            .dec   (sem_dec[t]),
            .cnt_o (sem_cnt[t])
        );
    end

    assign sync[TH_BIN] = is_wait[TH_BIN] || is_inc[TH_BIN] || (op[TH_BIN] == OP_FLUSH);
    assign sync[TH_RND] = is_wait[TH_RND] || is_inc[TH_RND] || (op[TH_RND] == OP_STORE_END);

    assign bin_flush = step[TH_BIN] && (op[TH_BIN] == OP_FLUSH);
    assign rnd_store = step[TH_RND] && (op[TH_RND] == OP_STORE_END);

    assign sem_inc[TH_BIN] = step[TH_RND] && is_inc[TH_RND];
    assign sem_inc[TH_RND] = bin_flush && st_q.pend_inc;

    always_comb begin
        st_d = st_q;
        if (ld_cur[TH_BIN] || bin_flush)        st_d.pend_inc = 1'b0;
        else if (step[TH_BIN] && is_inc[TH_BIN]) st_d.pend_inc = 1'b1;

        if (host_we && host_sel == HS_CLR_BIN) st_d.bin_cnt = '0;
        else if (bin_flush)                     st_d.bin_cnt = st_q.bin_cnt + 1'b1;

        if (host_we && host_sel == HS_CLR_RND) st_d.rnd_cnt = '0;
        else if (rnd_store)                     st_d.rnd_cnt = st_q.rnd_cnt + 1'b1;

        st_d.irq = bin_flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sem_to_bin    = sem_cnt[TH_BIN];
    assign sem_to_rnd    = sem_cnt[TH_RND];
    assign bin_flush_cnt = st_q.bin_cnt;
    assign rnd_done_cnt  = st_q.rnd_cnt;
    assign flush_irq     = st_q.irq;
endmodule

// File: rtl/cl_seq_chk.sv
module cl_seq_chk
    import cl_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int SEM_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_we,
    input logic                   host_thr,
    input logic [1:0]             host_sel,
    input logic [1:0]             fetch_req,
    input logic [1:0][ADDR_W-1:0] fetch_addr,
    input logic [1:0]             fetch_ack,
    input logic [1:0][31:0]       fetch_data,
    input logic [1:0]             cmd_valid,
    input logic [SEM_W-1:0]       sem_to_bin,
    input logic [SEM_W-1:0]       sem_to_rnd,
    input logic                   flush_irq
);
    logic bin_acc, rnd_acc, bin_host, rnd_host, bin_flush_seen, bin_wait_take;

    assign bin_acc  = fetch_req[0] && fetch_ack[0];
    assign rnd_acc  = fetch_req[1] && fetch_ack[1];
    assign bin_host = host_we && !host_thr && (host_sel[1] == 1'b0);
    assign rnd_host = host_we &&  host_thr && (host_sel[1] == 1'b0);
    assign bin_flush_seen = bin_acc && fetch_data[0][31:24] == OP_FLUSH;
    assign bin_wait_take  = bin_acc && fetch_data[0][31:24] == OP_SEM_WAIT && sem_to_bin != '0;

    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_acc && fetch_data[1][31:24] == OP_SEM_WAIT && sem_to_rnd == '0 && !rnd_host
        |=> $stable(fetch_addr[1]));

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bin_acc && !(fetch_data[0][31:24] == OP_SEM_WAIT && sem_to_bin == '0) && !bin_host
        |=> fetch_addr[0] == $past(fetch_addr[0]) + ADDR_W'(WORD_BYTES));

    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bin_flush_seen |=> flush_irq);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_flush_seen |=> !flush_irq);

    assert_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sem_to_bin == '1 && !bin_wait_take |=> sem_to_bin == '1);

    assert_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid[0] |-> bin_acc);

    assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_thr && host_sel == HS_CUR |=> !fetch_req[1]);
endmodule

bind cl_seq cl_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEM_W(SEM_W)) u_chk (.*);

// File: tb/sim_cl_seq.sv
module sim_cl_seq;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;
    localparam int SEM_W  = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   host_we = 1'b0;
    logic                   host_thr = 1'b0;
    logic [1:0]             host_sel = 2'd0;
    logic [ADDR_W-1:0]      host_wdata = '0;
    logic [1:0]             fetch_req;
    logic [1:0][ADDR_W-1:0] fetch_addr;
    logic [1:0]             fetch_ack;
    logic [1:0][31:0]       fetch_data;
    logic [1:0]             cmd_valid;
    logic [1:0][31:0]       cmd_word;
    logic [1:0]             thread_busy;
    logic [SEM_W-1:0]       sem_to_bin, sem_to_rnd;
    logic [CNT_W-1:0]       bin_flush_cnt, rnd_done_cnt;
    logic                   flush_irq;

    logic [31:0] mem0 [0:63];
    logic [31:0] mem1 [0:63];
    logic [1:0]  ack_en = 2'b11;
    logic [31:0] expq0 [$];
    logic [31:0] expq1 [$];
    int checks = 0, errors = 0, irq_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cl_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEM_W(SEM_W)) u0 (.*);

    always_comb begin
        fetch_data[0] = mem0[fetch_addr[0][7:2]];
        fetch_data[1] = mem1[fetch_addr[1][7:2]];
        fetch_ack     = ack_en;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare forwarded words with the scoreboard at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (flush_irq) irq_seen++;
            if (cmd_valid[0]) begin
                if (expq0.size() == 0) check("R4 unexpected bin word", cmd_word[0], 32'hx);
                else check("R4 bin word", cmd_word[0], expq0.pop_front());
            end
            if (cmd_valid[1]) begin
                if (expq1.size() == 0) check("R4 unexpected rnd word", cmd_word[1], 32'hx);
                else check("R4 rnd word", cmd_word[1], expq1.pop_front());
            end
        end
    end

    task automatic hwrite(input logic thr, input logic [1:0] sel, input logic [31:0] d);
        host_we = 1'b1; host_thr = thr; host_sel = sel; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic launch(input logic thr, input logic [31:0] s, input logic [31:0] e);
        hwrite(thr, 2'd0, s);
        hwrite(thr, 2'd1, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done(input int t);
        for (int i = 0; i < 500 && thread_busy[t]; i++) idle(1);
        idle(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mem0[i] = 32'h0; mem1[i] = 32'h0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 busy", {30'd0, thread_busy}, 32'd0);
        check("R1 req", {30'd0, fetch_req}, 32'd0);
        check("R1 sems", {24'd0, sem_to_bin, sem_to_rnd}, 32'd0);
        check("R1 counters", {16'd0, bin_flush_cnt, rnd_done_cnt}, 32'd0);
        check("R1 irq", {31'd0, flush_irq}, 32'd0);

        // R6 R9 R2: render list with increment, data, final store
        mem1[0] = 32'h13000000; mem1[1] = 32'h80000011; mem1[2] = 32'h12000000;
        expq1.push_back(32'h80000011);
        launch(1'b1, 32'h0, 32'h0C);
        wait_done(1);
        check("R2 render stops at end", {31'd0, thread_busy[1]}, 32'd0);
        check("R2 final address", fetch_addr[1], 32'h0C);
        check("R6 sem_to_bin", {28'd0, sem_to_bin}, 32'd1);
        check("R9 rnd_done_cnt", {24'd0, rnd_done_cnt}, 32'd1);

        // R5 R7 R8 R10: binning list, trailing increment after flush
        mem0[0] = 32'h14000000; mem0[1] = 32'h13000000; mem0[2] = 32'hA0000001;
        mem0[3] = 32'h11000000; mem0[4] = 32'h12000005; mem0[5] = 32'h13000000;
        expq0.push_back(32'hA0000001); expq0.push_back(32'h12000005);
        launch(1'b0, 32'h0, 32'h18);
        wait_done(0);
        check("R5 sem_to_bin consumed", {28'd0, sem_to_bin}, 32'd0);
        check("R7 sem_to_rnd at flush", {28'd0, sem_to_rnd}, 32'd1);
        check("R8 bin_flush_cnt", {24'd0, bin_flush_cnt}, 32'd1);
        check("R8 irq pulses", irq_seen, 1);
        check("R10 store on bin not counted", {24'd0, rnd_done_cnt}, 32'd1);
        idle(5);
        check("R7 trailing increment ignored", {28'd0, sem_to_rnd}, 32'd1);

        // R5 stall and release
        mem1[16] = 32'h14000000; mem1[17] = 32'h14000000; mem1[18] = 32'h80000022;
        expq1.push_back(32'h80000022);
        launch(1'b1, 32'h40, 32'h4C);
        idle(6);
        check("R5 stalled address", fetch_addr[1], 32'h44);
        check("R5 still busy", {31'd0, thread_busy[1]}, 32'd1);
        check("R5 sem_to_rnd drained", {28'd0, sem_to_rnd}, 32'd0);
        check("R5 nothing forwarded", expq1.size(), 1);
        mem0[8] = 32'h13000000; mem0[9] = 32'h11000000;
        launch(1'b0, 32'h20, 32'h28);
        wait_done(0);
        wait_done(1);
        check("R5 released", {31'd0, thread_busy[1]}, 32'd0);
        check("R5 sem_to_rnd after release", {28'd0, sem_to_rnd}, 32'd0);
        check("R8 second flush", {24'd0, bin_flush_cnt}, 32'd2);

        // R3 no acknowledge, R11 saturation, R10 flush on render
        for (int i = 32; i < 49; i++) mem1[i] = 32'h13000000;
        mem1[49] = 32'h11000077;
        expq1.push_back(32'h11000077);
        ack_en = 2'b01;
        launch(1'b1, 32'h80, 32'hC8);
        idle(4);
        check("R3 hold without ack", fetch_addr[1], 32'h80);
        check("R3 no effect without ack", {28'd0, sem_to_bin}, 32'd0);
        ack_en = 2'b11;
        wait_done(1);
        check("R11 saturated", {28'd0, sem_to_bin}, 32'd15);
        check("R10 flush on render not counted", {24'd0, bin_flush_cnt}, 32'd2);
        check("R10 no irq from render", irq_seen, 2);

        // R12 clears
        hwrite(1'b0, 2'd2, 32'h0);
        check("R12 flush count cleared", {24'd0, bin_flush_cnt}, 32'd0);
        check("R12 render count kept", {24'd0, rnd_done_cnt}, 32'd1);
        hwrite(1'b0, 2'd3, 32'h0);
        check("R12 render count cleared", {24'd0, rnd_done_cnt}, 32'd0);

        check("R4 bin scoreboard empty", expq0.size(), 0);
        check("R4 rnd scoreboard empty", expq1.size(), 0);
        finish_run();
    end
endmodule